// File: doc/BRIEF.md
# Nibble-Wide ROM Table-Lookup Pointer

This block lets a 4-bit datapath fetch constant bytes out of an 8-bit-wide program ROM. It holds a 12-bit byte pointer. Software fills the pointer four bits at a time, using three independent load strobes. The low, middle and high nibble of the pointer each have their own strobe.

Two kinds of read request exist. A low read returns bits [3:0] of the addressed byte and leaves the pointer where it is. A high read returns bits [7:4] and then steps the pointer to the next byte. A two-read sequence therefore walks a byte table nibble by nibble.

Read requests enter on a valid/ready handshake. Returned nibbles leave on a second valid/ready handshake. The load strobes are plain control pins. A small synchronous ROM model with computed contents sits inside the block so that it can be exercised on its own.

Back-pressure rules:
- A request is accepted on a clock edge where `rd_valid` and `rd_ready` are both high.
- `rd_ready` is high whenever the output slot is empty or is being drained in that same cycle.
- While `nib_valid` is high and `nib_ready` is low, the returned nibble is held unchanged and no request is accepted.

Top module: `dptr_lookup`

## Requirements
- R1: After reset the pointer is 000h, `rom_addr` is 0, `nib_valid` is 0 and `rd_ready` is 1.
- R2: A pulse on `ld_lo`, `ld_mid` or `ld_hi` copies `ld_nib` into pointer bits [3:0], [7:4] or [11:8] respectively. The other pointer bits keep their value.
- R3: An accepted low read (`rd_high`=0) returns bits [3:0] of the addressed byte and leaves the pointer unchanged.
- R4: An accepted high read (`rd_high`=1) returns bits [7:4] of the addressed byte. The pointer then increases by one.
- R5: `rom_addr` is pointer bits [10:0], so pointer bit 11 plays no part in addressing. The increment wraps from FFFh to 000h, and 7FFh steps to 800h.
- R6: `nib_valid` rises on the clock edge that follows the edge accepting a read.
- R7: While `nib_valid`=1 and `nib_ready`=0, `nib_data` stays stable and `rd_ready` is 0. A request offered in that state changes neither the pointer nor the output.
- R8: A load strobe and `rd_valid` are never high in the same cycle.
- R9: The ROM byte at address a (11 bits) is a[7:0] XOR (a[10:8] shifted left by 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_lo | input | 1 | Load pointer bits [3:0] from ld_nib |
| ld_mid | input | 1 | Load pointer bits [7:4] from ld_nib |
| ld_hi | input | 1 | Load pointer bits [11:8] from ld_nib |
| ld_nib | input | 4 | Nibble value for the load strobes |
| rd_valid | input | 1 | Read request offered |
| rd_high | input | 1 | 0: low read, 1: high read with pointer increment |
| rd_ready | output | 1 | Read request can be accepted |
| nib_valid | output | 1 | Returned nibble present |
| nib_ready | input | 1 | Consumer takes the returned nibble |
| nib_data | output | 4 | Returned nibble |
| rom_addr | output | 11 | ROM byte address driven from the pointer |

## Verification
The bench targets the pointer crossing 7FFh and FFFh. A design that used all twelve bits for addressing would fetch the wrong byte after 800h. A design with a wrong wrap would leave `rom_addr` at a wrong value.

It loads one nibble alone, to catch a strobe that disturbs its neighbours. It also mixes low and high reads, so that incrementing on the wrong read kind shows up as a wrong address and a shifted nibble stream.

Finally, it stalls the consumer while a request is offered. A design ignoring back-pressure would either change the held nibble or advance the pointer.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned PTR_W  = 12;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ROM_AW = 11;

  typedef enum logic {
    RD_LOW  = 1'b0,
    RD_HIGH = 1'b1
  } rd_kind_e;
endpackage

// File: rtl/dptr_reg.sv
module dptr_reg #(
  parameter int unsigned PTR_W = 12,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned NNIB = PTR_W / NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NNIB-1:0]  ld_en,
  input  logic [NIB_W-1:0] ld_nib,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] ld_val;

  for (genvar g = 0; g < NNIB; g++) begin : g_field
    assign ld_val[g*NIB_W +: NIB_W] = ld_en[g] ? ld_nib : ptr_q[g*NIB_W +: NIB_W];
  end

  always_comb begin
    if (inc) ptr_d = ptr_q + PTR_W'(1);
    else     ptr_d = ld_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (ptr == PTR_W'($past(ptr) + 1)));

  // R2
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && (ld_en == '0)) |=> $stable(ptr));
endmodule

// File: rtl/dptr_rom.sv
module dptr_rom #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);
  function automatic logic [DATA_W-1:0] content(input logic [ADDR_W-1:0] a);
    return a[DATA_W-1:0] ^ {a[ADDR_W-1:DATA_W], {(DATA_W-HI_W){1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= content(addr);
  end
endmodule

// File: rtl/dptr_nibout.sv
module dptr_nibout #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned NNIB = DATA_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_high,
  input  logic [DATA_W-1:0] byte_q,
  output logic              slot_free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  out_data
);
  logic valid_q;
  logic high_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      high_q  <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
      high_q  <= take_high;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NNIB; i++) begin
      if ((high_q && i == NNIB - 1) || (!high_q && i == 0))
        out_data = byte_q[i*NIB_W +: NIB_W];
    end
  end

  assign out_valid = valid_q;
  assign slot_free = !valid_q || out_ready;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
endmodule

// File: rtl/dptr_lookup.sv
module dptr_lookup
  import dptr_pkg::*;
#(
  parameter int unsigned PW  = PTR_W,
  parameter int unsigned NW  = NIB_W,
  parameter int unsigned BW  = BYTE_W,
  parameter int unsigned AW  = ROM_AW,
  localparam int unsigned NF = PW / NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_mid,
  input  logic          ld_hi,
  input  logic [NW-1:0] ld_nib,
  input  logic          rd_valid,
  input  logic          rd_high,
  output logic          rd_ready,
  output logic          nib_valid,
  input  logic          nib_ready,
  output logic [NW-1:0] nib_data,
  output logic [AW-1:0] rom_addr
);
  logic [PW-1:0] ptr;
  logic [NF-1:0] ld_en;
  logic          accept;
  logic          step;
  logic [BW-1:0] rom_q;
  rd_kind_e      kind;

  assign ld_en  = NF'({ld_hi, ld_mid, ld_lo});
  assign kind   = rd_kind_e'(rd_high);
  assign accept = rd_valid && rd_ready;
  assign step   = accept && (kind == RD_HIGH);

  dptr_reg #(.PTR_W(PW), .NIB_W(NW)) u_reg (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_nib(ld_nib),
    .inc(step), .ptr(ptr)
  );

  assign rom_addr = ptr[AW-1:0];

  dptr_rom #(.ADDR_W(AW), .DATA_W(BW)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(accept), .addr(rom_addr), .q(rom_q)
  );

  dptr_nibout #(.DATA_W(BW), .NIB_W(NW)) u_out (
    .clk(clk), .rst_n(rst_n), .take(accept), .take_high(kind == RD_HIGH),
    .byte_q(rom_q), .slot_free(rd_ready), .out_valid(nib_valid),
    .out_ready(nib_ready), .out_data(nib_data)
  );

  // R8
  load_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ld_lo || ld_mid || ld_hi) && rd_valid));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && !nib_ready) |-> !rd_ready);
endmodule

// File: tb/tb_dptr_lookup.sv
module tb_dptr_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_lo = 0, ld_mid = 0, ld_hi = 0;
  logic [3:0] ld_nib = '0;
  logic rd_valid = 0, rd_high = 0;
  logic rd_ready, nib_valid;
  logic nib_ready = 1'b1;
  logic [3:0] nib_data;
  logic [10:0] rom_addr;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_ptr = '0;

  typedef struct { logic [3:0] val; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  dptr_lookup dut (
    .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_mid(ld_mid), .ld_hi(ld_hi),
    .ld_nib(ld_nib), .rd_valid(rd_valid), .rd_high(rd_high), .rd_ready(rd_ready),
    .nib_valid(nib_valid), .nib_ready(nib_ready), .nib_data(nib_data),
    .rom_addr(rom_addr)
  );

  function automatic logic [7:0] rom_model(input logic [10:0] a);
    logic [7:0] hi3;
    hi3 = {a[10:8], 5'd0};
    return a[7:0] ^ hi3;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each output transfer
  always @(negedge clk) begin
    if (rst_n && nib_valid && nib_ready) begin
      if (sb.size() == 0) begin
        chk("R3/R4 unexpected nibble", {8'd0, nib_data}, 12'hFFF);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, {8'd0, nib_data}, {8'd0, it.val});
      end
    end
  end

  task automatic load(input int field, input logic [3:0] v);
    @(negedge clk);
    ld_nib = v;
    ld_lo  = (field == 0);
    ld_mid = (field == 1);
    ld_hi  = (field == 2);
    @(negedge clk);
    ld_lo = 0; ld_mid = 0; ld_hi = 0;
    m_ptr[field*4 +: 4] = v;
  endtask

  task automatic rd(input bit hi, input string tag);
    logic [7:0] b;
    item_t it;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1; rd_high = hi;
    b = rom_model(m_ptr[10:0]);
    it.val = hi ? b[7:4] : b[3:0];
    it.tag = tag;
    sb.push_back(it);
    if (hi) m_ptr = m_ptr + 12'd1;
    @(negedge clk);
    rd_valid = 0; rd_high = 0;
    chk("R6 valid after accept", {11'd0, nib_valid}, 12'd1);
    chk({tag, " address"}, {1'b0, rom_addr}, {1'b0, m_ptr[10:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", {11'd0, nib_valid}, 12'd0);
    chk("R1 addr", {1'b0, rom_addr}, 12'd0);
    chk("R1 ready", {11'd0, rd_ready}, 12'd1);
    rst_n = 1'b1;

    // R2 nibble loads
    load(0, 4'h7); load(1, 4'h7); load(2, 4'h7);
    @(negedge clk);
    chk("R2 three loads", {1'b0, rom_addr}, 12'h777);
    rd(0, "R3 low read");
    rd(1, "R4 high read");
    load(1, 4'hA);
    @(negedge clk);
    chk("R2 middle load only", {1'b0, rom_addr}, 12'h7A8);
    rd(0, "R9 low content");
    rd(0, "R3 repeat low");
    rd(1, "R9 high content");

    // R5 crossing 7FFh
    load(0, 4'hC); load(1, 4'hF); load(2, 4'h7);
    for (int i = 0; i < 6; i++) rd(1, "R5 walk past 7FF");
    chk("R5 bit11 set", m_ptr, 12'h802);
    load(0, 4'hB); load(1, 4'hA); load(2, 4'h8);
    rd(0, "R5 bit11 ignored low");
    rd(1, "R5 bit11 ignored high");

    // R5 wrap at FFFh
    load(0, 4'hF); load(1, 4'hF); load(2, 4'hF);
    @(negedge clk);
    chk("R5 addr at FFF", {1'b0, rom_addr}, 12'h7FF);
    rd(1, "R5 wrap read");
    chk("R5 wrap to 000", {1'b0, rom_addr}, 12'h000);

    // R7 back-pressure
    load(0, 4'h3); load(1, 4'h5); load(2, 4'h1);
    @(negedge clk);
    nib_ready = 0;
    rd(1, "R7 stalled high read");
    held = nib_data;
    @(negedge clk);
    rd_valid = 1; rd_high = 1;
    repeat (2) @(negedge clk);
    chk("R7 ready low", {11'd0, rd_ready}, 12'd0);
    chk("R7 data held", {8'd0, nib_data}, {8'd0, held});
    chk("R7 valid held", {11'd0, nib_valid}, 12'd1);
    chk("R7 pointer kept", {1'b0, rom_addr}, {1'b0, m_ptr[10:0]});
    rd_valid = 0; rd_high = 0;
    nib_ready = 1;
    @(negedge clk);
    chk("R7 drained", {11'd0, nib_valid}, 12'd0);

    // mixed pattern
    for (int k = 0; k < 8; k++) begin
      load(0, 4'(k * 3)); load(1, 4'(k + 9));
      rd(k[0], "R3/R4 mixed");
      rd(1, "R4 mixed high");
    end

    repeat (3) @(negedge clk);
    chk("R3/R4 scoreboard empty", 12'(sb.size()), 12'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule